// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block caches virtual-to-physical page translations so an address can be translated without a page walk. A 32-bit virtual address is split into a 12-bit page offset and a 20-bit virtual page number. The low four bits of the page number select one of 16 sets. The upper sixteen bits are compared against the tags held in the four ways of that set. A lookup reports exactly one of three outcomes: a hit with the translated physical address, a miss, or a protection fault raised from the access rights cached with the entry.

Entries arrive through a fill port that carries the result of a page walk done elsewhere. The block never walks tables and does not handle faults; on a miss it only raises its miss output. Each set has a round-robin pointer that picks the way to replace, and ways marked global are never replaced. A flush input invalidates every non-global entry in one cycle. Global entries stay resident until a fill carrying the same tag rewrites them.

Top module: `tlb_top`

## Requirements
- R1: While `rst` is high at a clock edge, all entries become invalid, every replacement pointer returns to way 0, and all response outputs are low with `resp_paddr` zero.
- R2: A request is captured on the edge where `req_valid` is high. During the following cycle exactly one of `resp_hit`, `resp_miss`, `resp_fault` is high. After an edge where `req_valid` was low, all three are low.
- R3: The set index is `req_vaddr[15:12]` and the tag is `req_vaddr[31:16]`. A request hits only when a valid way of that set holds an equal tag; otherwise it misses.
- R4: On a hit, `resp_paddr` equals the stored 20-bit page number followed by `req_vaddr[11:0]`. In every other cycle, `resp_paddr` is zero.
- R5: A matching entry raises `resp_fault` instead of `resp_hit` when a write (`req_write`=1) targets an entry filled with `fill_writable`=0. It does the same when a user access (`req_user`=1) targets an entry filled with `fill_user`=0.
- R6: A fill writes a valid entry into set `fill_vaddr[15:12]` with tag `fill_vaddr[31:16]`. The victim is chosen by that set's pointer: the first non-global way, scanning upward from the pointer with wrap-around. The pointer then moves to the way after the victim.
- R7: A fill that finds all four ways of its set global, and no way with its tag, is dropped.
- R8: A valid global entry is never chosen as a victim and survives a flush.
- R9: `flush` clears the valid bit of every non-global entry at one edge. A fill at the same edge is written after the flush and stays valid.
- R10: A lookup and a fill presented at the same edge see the contents from before the fill.
- R11: A fill whose tag is already valid in its set rewrites that way in place and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Lookup is a write |
| req_user | input | 1 | Lookup is made in user mode |
| resp_hit | output | 1 | Translation found and allowed |
| resp_miss | output | 1 | No valid matching entry |
| resp_fault | output | 1 | Matching entry forbids the access |
| resp_paddr | output | 32 | Physical address on a hit, else zero |
| fill_valid | input | 1 | Write a page-walk result |
| fill_vaddr | input | 32 | Virtual address of the filled page |
| fill_ppn | input | 20 | Physical page number of the filled page |
| fill_writable | input | 1 | Page permits writes |
| fill_user | input | 1 | Page permits user access |
| fill_global | input | 1 | Page is exempt from replacement and flush |
| flush | input | 1 | Invalidate all non-global entries |

## Verification
Every lookup result is due in the cycle after the edge that captured the request. Fills and flushes change what a lookup presented at the next edge or later can see. The bench drives inputs at the falling edge and keeps a behavioural model. Before each rising edge, the model computes the expected response from its state before that edge, then applies any flush and fill. The bench compares all four outputs at the next falling edge, so every cycle, idle ones included, is compared against the expectation for exactly one edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int PPN_W = 20;
    localparam int WAYS  = 4;
    localparam int SETS  = 16;

    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int PA_W  = PPN_W + OFF_W;

    typedef struct packed {
        logic             valid;
        logic             glob;
        logic             wr_ok;
        logic             usr_ok;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;

    typedef struct packed {
        logic            valid;
        logic [VA_W-1:0] vaddr;
        logic            write;
        logic            user;
    } tlb_req_t;

    typedef enum logic [1:0] {
        LK_MISS  = 2'd0,
        LK_HIT   = 2'd1,
        LK_FAULT = 2'd2
    } lk_result_e;

    function automatic logic [IDX_W-1:0] set_of(input logic [VA_W-1:0] va);
        return va[OFF_W +: IDX_W];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: TAG_W];
    endfunction
endpackage

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  logic [WAY_W-1:0] start,
    input  logic [WAYS-1:0]  locked,
    output logic             found,
    output logic [WAY_W-1:0] way
);
    logic [WAY_W-1:0] cand;

    // Scan from the pointer upward with wrap; the nearest unlocked way wins.
    always_comb begin
        found = 1'b0;
        way   = start;
        cand  = start;
        for (int k = WAYS - 1; k >= 0; k--) begin
            cand = start + WAY_W'(k);
            if (!locked[cand]) begin
                found = 1'b1;
                way   = cand;
            end
        end
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  tlb_entry_t [WAYS-1:0] ways,
    input  logic [TAG_W-1:0]      tag,
    input  logic                  is_write,
    input  logic                  is_user,
    output lk_result_e            result,
    output logic [PPN_W-1:0]      ppn
);
    always_comb begin
        result = LK_MISS;
        ppn    = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (ways[w].valid && ways[w].tag == tag) begin
                if ((is_write && !ways[w].wr_ok) || (is_user && !ways[w].usr_ok)) begin
                    result = LK_FAULT;
                    ppn    = '0;
                end else begin
                    result = LK_HIT;
                    ppn    = ways[w].ppn;
                end
            end
        end
    end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  fill_en,
    input  logic [IDX_W-1:0]      fill_set,
    input  tlb_entry_t            fill_ent,
    input  logic [IDX_W-1:0]      rd_set,
    output tlb_entry_t [WAYS-1:0] rd_ways
);
    tlb_entry_t [WAYS-1:0] mem [SETS];
    logic [WAY_W-1:0]      ptr [SETS];

    tlb_entry_t [WAYS-1:0] cur;
    logic [WAYS-1:0]       same_tag;
    logic [WAYS-1:0]       locked;
    logic                  refill;
    logic [WAY_W-1:0]      refill_way;
    logic                  vic_found;
    logic [WAY_W-1:0]      vic_way;

    always_comb rd_ways = mem[rd_set];

    always_comb begin
        cur        = mem[fill_set];
        refill     = 1'b0;
        refill_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            same_tag[w] = cur[w].valid && (cur[w].tag == fill_ent.tag);
            locked[w]   = cur[w].valid && cur[w].glob;
            if (same_tag[w]) begin
                refill     = 1'b1;
                refill_way = WAY_W'(w);
            end
        end
    end

    tlb_victim u_victim (
        .start  (ptr[fill_set]),
        .locked (locked),
        .found  (vic_found),
        .way    (vic_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                ptr[s] <= '0;
                for (int w = 0; w < WAYS; w++) mem[s][w] <= '0;
            end
        end else begin
            if (flush) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        if (!mem[s][w].glob) mem[s][w].valid <= 1'b0;
            end
            if (fill_en) begin
                if (refill) begin
                    mem[fill_set][refill_way] <= fill_ent;
                end else if (vic_found) begin
                    mem[fill_set][vic_way] <= fill_ent;
                    ptr[fill_set]          <= vic_way + 1'b1;
                end
            end
        end
    end

    // Occupancy views used only by the checks below.
    logic [SETS*WAYS-1:0] glob_vec;
    logic                 plain_any;
    always_comb begin
        plain_any = 1'b0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                glob_vec[s*WAYS+w] = mem[s][w].valid && mem[s][w].glob;
                if (mem[s][w].valid && !mem[s][w].glob) plain_any = 1'b1;
            end
    end

    // R9: a flush with no fill leaves no non-global entry valid.
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
        (flush && !fill_en) |=> !plain_any);

    // R8: without a fill, the set of resident global entries never shrinks.
    a_r8_globals_kept: assert property (@(posedge clk) disable iff (rst)
        !fill_en |=> ($countones(glob_vec) == $past($countones(glob_vec))));
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    output logic             resp_hit,
    output logic             resp_miss,
    output logic             resp_fault,
    output logic [31:0]      resp_paddr,
    input  logic             fill_valid,
    input  logic [31:0]      fill_vaddr,
    input  logic [19:0]      fill_ppn,
    input  logic             fill_writable,
    input  logic             fill_user,
    input  logic             fill_global,
    input  logic             flush
);
    tlb_req_t              req_q;
    tlb_entry_t [WAYS-1:0] rd_ways;
    tlb_entry_t [WAYS-1:0] snap_q;
    tlb_entry_t            fill_ent;
    lk_result_e            result;
    logic [PPN_W-1:0]      hit_ppn;

    always_comb begin
        fill_ent.valid  = 1'b1;
        fill_ent.glob   = fill_global;
        fill_ent.wr_ok  = fill_writable;
        fill_ent.usr_ok = fill_user;
        fill_ent.tag    = tag_of(fill_vaddr);
        fill_ent.ppn    = fill_ppn;
    end

    tlb_store u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .fill_en  (fill_valid),
        .fill_set (set_of(fill_vaddr)),
        .fill_ent (fill_ent),
        .rd_set   (set_of(req_vaddr)),
        .rd_ways  (rd_ways)
    );

    // The selected set is copied at the request edge, before any fill lands.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            snap_q <= '0;
        end else begin
            req_q.valid <= req_valid;
            req_q.vaddr <= req_vaddr;
            req_q.write <= req_write;
            req_q.user  <= req_user;
            if (req_valid) snap_q <= rd_ways;
        end
    end

    tlb_match u_match (
        .ways     (snap_q),
        .tag      (tag_of(req_q.vaddr)),
        .is_write (req_q.write),
        .is_user  (req_q.user),
        .result   (result),
        .ppn      (hit_ppn)
    );

    always_comb begin
        resp_hit   = req_q.valid && (result == LK_HIT);
        resp_miss  = req_q.valid && (result == LK_MISS);
        resp_fault = req_q.valid && (result == LK_FAULT);
        resp_paddr = resp_hit ? {hit_ppn, req_q.vaddr[OFF_W-1:0]} : '0;
    end

    a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ($countones({resp_hit, resp_miss, resp_fault}) == 1));

    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(resp_hit || resp_miss || resp_fault));

    a_r4_offset_kept: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!resp_hit || resp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    a_r4_zero_addr: assert property (@(posedge clk) disable iff (rst)
        !resp_hit |-> (resp_paddr == '0));
endmodule

// File: tb/tlb_top_tb.sv
module tlb_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        resp_hit, resp_miss, resp_fault;
    logic [31:0] resp_paddr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_vaddr = '0;
    logic [19:0] fill_ppn = '0;
    logic        fill_writable = 1'b0;
    logic        fill_user = 1'b0;
    logic        fill_global = 1'b0;
    logic        flush = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state: entry index = set*4 + way.
    bit mv [64];
    bit mg [64];
    bit mw [64];
    bit mu [64];
    int mtag [64];
    int mppn [64];
    int mptr [16];

    bit          e_hit, e_miss, e_fault;
    logic [31:0] e_pa;

    always #10 clk = ~clk;

    tlb_top u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .resp_hit(resp_hit), .resp_miss(resp_miss),
        .resp_fault(resp_fault), .resp_paddr(resp_paddr),
        .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_ppn(fill_ppn),
        .fill_writable(fill_writable), .fill_user(fill_user),
        .fill_global(fill_global), .flush(flush)
    );

    function automatic logic [31:0] mk(input int tag, input int set, input int off);
        return {tag[15:0], set[3:0], off[11:0]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 64; i++) begin
            mv[i] = 0; mg[i] = 0; mw[i] = 0; mu[i] = 0; mtag[i] = 0; mppn[i] = 0;
        end
        for (int s = 0; s < 16; s++) mptr[s] = 0;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (resp_hit !== e_hit || resp_miss !== e_miss ||
            resp_fault !== e_fault || resp_paddr !== e_pa) begin
            errors++;
            $display("FAIL %s: hit/miss/fault=%b%b%b paddr=%h, expected %b%b%b paddr=%h",
                     tag, resp_hit, resp_miss, resp_fault, resp_paddr,
                     e_hit, e_miss, e_fault, e_pa);
        end
    endtask

    // One clock: predict from the state before the edge, update the model, compare.
    task automatic step(input string tag);
        int s, t, fs, ft, rw, vw;
        bit fnd;
        e_hit = 0; e_miss = 0; e_fault = 0; e_pa = '0;
        if (req_valid) begin
            s = int'(req_vaddr[15:12]);
            t = int'(req_vaddr[31:16]);
            fnd = 0;
            for (int w = 0; w < 4; w++) begin
                if (mv[s*4+w] && mtag[s*4+w] == t) begin
                    fnd = 1;
                    if ((req_write && !mw[s*4+w]) || (req_user && !mu[s*4+w])) e_fault = 1;
                    else begin
                        e_hit = 1;
                        e_pa  = {mppn[s*4+w][19:0], req_vaddr[11:0]};
                    end
                end
            end
            if (!fnd) e_miss = 1;
        end
        fs = int'(fill_vaddr[15:12]);
        ft = int'(fill_vaddr[31:16]);
        rw = -1;
        vw = -1;
        if (fill_valid) begin
            for (int w = 0; w < 4; w++)
                if (mv[fs*4+w] && mtag[fs*4+w] == ft && rw < 0) rw = w;
            if (rw < 0)
                for (int k = 0; k < 4; k++) begin
                    int c;
                    c = (mptr[fs] + k) % 4;
                    if (vw < 0 && !(mv[fs*4+c] && mg[fs*4+c])) vw = c;
                end
        end
        if (flush)
            for (int i = 0; i < 64; i++) if (!mg[i]) mv[i] = 0;
        if (fill_valid && (rw >= 0 || vw >= 0)) begin
            int i;
            i = fs*4 + ((rw >= 0) ? rw : vw);
            mv[i] = 1; mg[i] = fill_global; mw[i] = fill_writable; mu[i] = fill_user;
            mtag[i] = ft; mppn[i] = int'(fill_ppn);
            if (rw < 0) mptr[fs] = (vw + 1) % 4;
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic look(input logic [31:0] va, input bit wr, input bit usr, input string tag);
        req_valid = 1; req_vaddr = va; req_write = wr; req_user = usr;
        step(tag);
        req_valid = 0; req_write = 0; req_user = 0;
    endtask

    task automatic load(input logic [31:0] va, input int ppn, input bit wr, input bit usr,
                        input bit glb, input string tag);
        fill_valid = 1; fill_vaddr = va; fill_ppn = ppn[19:0];
        fill_writable = wr; fill_user = usr; fill_global = glb;
        step(tag);
        fill_valid = 0; fill_global = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state at the ports
        e_hit = 0; e_miss = 0; e_fault = 0; e_pa = '0;
        compare("R1");
        look(mk(1, 3, 0), 0, 0, "R1");
        step("R2");

        // R3, R4: basic fill and translation
        load(mk(16'h12, 3, 0), 20'hABCDE, 1, 1, 0, "R6");
        look(mk(16'h12, 3, 12'h5A7), 0, 0, "R4");
        look(mk(16'h12, 3, 12'hFFF), 1, 1, "R4");
        look(mk(16'h12, 4, 12'h5A7), 0, 0, "R3");
        look(mk(16'h13, 3, 12'h5A7), 0, 0, "R3");
        look(mk(16'h12, 3, 0), 0, 0, "R2");
        look(mk(16'h12, 3, 1), 0, 0, "R2");
        step("R2");

        // R5: protection
        load(mk(16'h20, 5, 0), 20'h11111, 0, 1, 0, "R6");
        look(mk(16'h20, 5, 12'h010), 1, 0, "R5");
        look(mk(16'h20, 5, 12'h010), 0, 1, "R5");
        load(mk(16'h21, 5, 0), 20'h22222, 1, 0, 0, "R6");
        look(mk(16'h21, 5, 12'h020), 0, 1, "R5");
        look(mk(16'h21, 5, 12'h020), 1, 0, "R5");

        // R6: round-robin replacement in set 7
        for (int k = 0; k < 5; k++) load(mk(16'h30 + k, 7, 0), 20'h30000 + k, 1, 1, 0, "R6");
        for (int k = 0; k < 5; k++) look(mk(16'h30 + k, 7, 12'h123), 0, 0, "R6");

        // R11: refill in place, pointer unchanged
        load(mk(16'h32, 7, 0), 20'h9ABCD, 1, 1, 0, "R11");
        look(mk(16'h32, 7, 12'h444), 0, 0, "R11");
        load(mk(16'h35, 7, 0), 20'h35035, 1, 1, 0, "R11");
        for (int k = 1; k < 6; k++) look(mk(16'h30 + k, 7, 12'h004), 0, 0, "R11");

        // R8: global entry is skipped by replacement
        load(mk(16'h40, 9, 0), 20'h40404, 1, 1, 1, "R8");
        for (int k = 1; k < 7; k++) load(mk(16'h40 + k, 9, 0), 20'h41000 + k, 1, 1, 0, "R8");
        for (int k = 0; k < 7; k++) look(mk(16'h40 + k, 9, 12'h0AA), 0, 0, "R8");

        // R7: fully global set drops fills
        for (int k = 0; k < 4; k++) load(mk(16'h50 + k, 10, 0), 20'h50000 + k, 1, 1, 1, "R7");
        load(mk(16'h54, 10, 0), 20'h54545, 1, 1, 0, "R7");
        for (int k = 0; k < 5; k++) look(mk(16'h50 + k, 10, 12'h777), 0, 0, "R7");

        // R9: flush clears non-global only
        flush = 1; step("R9"); flush = 0;
        look(mk(16'h12, 3, 12'h5A7), 0, 0, "R9");
        look(mk(16'h35, 7, 0), 0, 0, "R9");
        look(mk(16'h40, 9, 12'h001), 0, 0, "R8");
        look(mk(16'h52, 10, 12'h002), 0, 0, "R8");
        // R9: flush and fill at the same edge keep the fill
        flush = 1;
        load(mk(16'h60, 2, 0), 20'h60606, 1, 1, 0, "R9");
        flush = 0;
        look(mk(16'h60, 2, 12'h321), 0, 0, "R9");

        // R10: lookup and fill at the same edge see the old contents
        req_valid = 1; req_vaddr = mk(16'h70, 4, 12'h00C);
        load(mk(16'h70, 4, 0), 20'h70707, 1, 1, 0, "R10");
        req_valid = 0;
        look(mk(16'h70, 4, 12'h00C), 0, 0, "R10");
        req_valid = 1; req_vaddr = mk(16'h70, 4, 12'h00D);
        load(mk(16'h70, 4, 0), 20'h0F0F0, 0, 1, 0, "R10");
        req_valid = 0;
        look(mk(16'h70, 4, 12'h00D), 1, 0, "R10");
        step("R2");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule